// File: doc/BRIEF.md
# RTC Extended Status and Control Register

This block is one 8-bit register of a real-time clock. It lives at offset 0x4A of the second register bank. It keeps three sticky event flags: wake alarm, kickstart and RAM-clear request. Hardware sets each flag, and software clears it by writing 0. Software may also write 1 to a flag to force an interrupt. The register also shows the live battery status and an update-in-progress indicator. It holds a power-control bit that drives an active-low power output. Hardware clears that bit whenever an enabled wake or kickstart flag is pending.

Software accesses the register through a plain synchronous port. Writes take effect on the clock edge, and reads are combinational on the address. The timekeeping counters, the alarm comparators and battery sensing sit outside the block. They deliver single-cycle strobes and levels. The RAM-clear pin is asynchronous, so it is synchronized before its falling edge is detected.

The update indicator is a two-state machine. In `UPD_IDLE`, an `upd_pending` strobe takes the transition *arm* into `UPD_BUSY`. In `UPD_BUSY`, an `upd_done` strobe takes the transition *finish* back to `UPD_IDLE`. When neither strobe applies, each state holds. The indicator bit reads 1 exactly while the machine is in `UPD_BUSY`.

Top module: `rtc_xstat_reg`

## Requirements
- R1: After reset, the register reads {batt_ok, 7'b000_1000}: all flags 0, update bit 0, reserved bits 0, power-control bit (bit 3) 1, and `pwr_n` high.
- R2: Bit 7 always equals the current `batt_ok` input, and writes to bit 7 have no effect.
- R3: Bit 6 becomes 1 one clock after an `upd_pending` strobe seen in `UPD_IDLE`. It returns to 0 one clock after an `upd_done` strobe seen in `UPD_BUSY`. Writes to bit 6 have no effect.
- R4: A `wake_evt` strobe sets bit 1 (wake flag) on the next edge, and a `kick_evt` strobe sets bit 0 (kickstart flag) on the next edge.
- R5: While `ramclr_en` is 1, a high-to-low transition of `ramclr_n` sets bit 2 (RAM-clear flag) on the third rising edge after the input falls. While `ramclr_en` is 0, the transition is ignored.
- R6: A register write of 0 to bits 2..0 clears those flags. A write of 1 sets them.
- R7: When a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.
- R8: Bit 3 is writable, and `pwr_n` equals bit 3, so the output is low when the bit is 0.
- R9: If (bit 1 and `wake_ie`) or (bit 0 and `kick_ie`) holds before an edge, bit 3 is 0 after that edge, even if a write of 1 to bit 3 occurs in that cycle.
- R10: Bits 5..4 store the written value and affect nothing else.
- R11: `irq` is 1 exactly when (bit 2 and `rf_ie`) or (bit 1 and `wake_ie`) or (bit 0 and `kick_ie`).
- R12: A write with another address or with `bank_sel` 0 changes nothing. A read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 1 | Register bank select |
| addr | input | 7 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when not addressed) |
| batt_ok | input | 1 | Auxiliary battery good level |
| upd_pending | input | 1 | Strobe: update about to start |
| upd_done | input | 1 | Strobe: update finished |
| wake_evt | input | 1 | Strobe: wake alarm match |
| kick_evt | input | 1 | Strobe: kickstart event |
| ramclr_n | input | 1 | Asynchronous RAM-clear pin, active low |
| ramclr_en | input | 1 | Enable for RAM-clear flag setting |
| wake_ie | input | 1 | Wake flag interrupt enable |
| kick_ie | input | 1 | Kickstart flag interrupt enable |
| rf_ie | input | 1 | RAM-clear flag interrupt enable |
| pwr_n | output | 1 | Power output, active low |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: address width 7, register at 0x4A in bank 1, and a two-stage synchronizer. With these values the three-edge RAM-clear latency can be observed, and random accesses to neighbouring addresses and to bank 0 exercise the decode. A fixed-seed random stream of strobes, writes, enable changes and pin toggles runs against a bench model. It reaches same-cycle collisions between hardware sets, written zeros and automatic power-bit clears. Directed steps pin down reset, battery tracking and the arm/finish transitions.

// File: rtl/rtc_xstat_pkg.sv
package rtc_xstat_pkg;
    localparam int REG_W      = 8;
    localparam int BIT_BATT   = 7;
    localparam int BIT_UIP    = 6;
    localparam int BIT_RES_HI = 5;
    localparam int BIT_RES_LO = 4;
    localparam int BIT_PAB    = 3;
    localparam int BIT_RF     = 2;
    localparam int BIT_WF     = 1;
    localparam int BIT_KF     = 0;
    localparam int N_FLAGS    = 3;
    localparam int RES_W      = BIT_RES_HI - BIT_RES_LO + 1;

    typedef enum logic [0:0] {
        UPD_IDLE = 1'b0,
        UPD_BUSY = 1'b1
    } upd_state_t;
endpackage

// File: rtl/rtc_xstat_sync.sv
module rtc_xstat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // chain[0..STAGES-1] synchronize; chain[STAGES] holds the previous sample
    genvar g;
    generate
        for (g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/rtc_xstat_upd_fsm.sv
module rtc_xstat_upd_fsm
    import rtc_xstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_pending,
    input  logic upd_done,
    output logic busy
);
    upd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        unique case (state_q)
            UPD_IDLE: begin
                if (upd_pending) state_d = UPD_BUSY;
            end
            UPD_BUSY: begin
                busy = 1'b1;
                if (upd_done) state_d = UPD_IDLE;
            end
            default: state_d = UPD_IDLE;
        endcase
    end
endmodule

// File: rtl/rtc_xstat_flags.sv
module rtc_xstat_flags
    import rtc_xstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             wake_evt,
    input  logic             kick_evt,
    input  logic             rf_set,
    input  logic             wake_ie,
    input  logic             kick_ie,
    output logic [N_FLAGS-1:0] flags,
    output logic             pab,
    output logic [RES_W-1:0] res
);
    logic [N_FLAGS-1:0] hw_set;
    logic               auto_clr;

    always_comb begin
        hw_set         = '0;
        hw_set[BIT_KF] = kick_evt;
        hw_set[BIT_WF] = wake_evt;
        hw_set[BIT_RF] = rf_set;
    end

    assign auto_clr = (flags[BIT_WF] & wake_ie) | (flags[BIT_KF] & kick_ie);

    genvar f;
    generate
        for (f = 0; f < N_FLAGS; f++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         flags[f] <= 1'b0;
                else if (hw_set[f]) flags[f] <= 1'b1;
                else if (wr_hit)    flags[f] <= wdata[f];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pab <= 1'b1;
        else if (auto_clr) pab <= 1'b0;
        else if (wr_hit)   pab <= wdata[BIT_PAB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      res <= '0;
        else if (wr_hit) res <= wdata[BIT_RES_HI:BIT_RES_LO];
    end
endmodule

// File: rtl/rtc_xstat_reg.sv
module rtc_xstat_reg
    import rtc_xstat_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 7'h4A,
    parameter logic              REG_BANK    = 1'b1,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              batt_ok,
    input  logic              upd_pending,
    input  logic              upd_done,
    input  logic              wake_evt,
    input  logic              kick_evt,
    input  logic              ramclr_n,
    input  logic              ramclr_en,
    input  logic              wake_ie,
    input  logic              kick_ie,
    input  logic              rf_ie,
    output logic              pwr_n,
    output logic              irq
);
    logic               sel_hit;
    logic               wr_hit;
    logic               ramclr_fall;
    logic               uip;
    logic [N_FLAGS-1:0] flags;
    logic               pab;
    logic [RES_W-1:0]   res;
    logic [REG_W-1:0]   reg_q;

    assign sel_hit = (bank_sel == REG_BANK) && (addr == REG_ADDR);
    assign wr_hit  = wr_en & sel_hit;

    rtc_xstat_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ramclr_n),
        .fall  (ramclr_fall)
    );

    rtc_xstat_upd_fsm u_upd (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_pending (upd_pending),
        .upd_done    (upd_done),
        .busy        (uip)
    );

    rtc_xstat_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wdata    (wdata),
        .wake_evt (wake_evt),
        .kick_evt (kick_evt),
        .rf_set   (ramclr_fall & ramclr_en),
        .wake_ie  (wake_ie),
        .kick_ie  (kick_ie),
        .flags    (flags),
        .pab      (pab),
        .res      (res)
    );

    always_comb begin
        reg_q                        = '0;
        reg_q[BIT_BATT]              = batt_ok;
        reg_q[BIT_UIP]               = uip;
        reg_q[BIT_RES_HI:BIT_RES_LO] = res;
        reg_q[BIT_PAB]               = pab;
        reg_q[N_FLAGS-1:0]           = flags;
    end

    assign rdata = sel_hit ? reg_q : '0;
    assign pwr_n = pab;
    assign irq   = (flags[BIT_RF] & rf_ie) | (flags[BIT_WF] & wake_ie)
                 | (flags[BIT_KF] & kick_ie);
endmodule

// File: rtl/rtc_xstat_chk.sv
module rtc_xstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_pending,
    input logic       upd_done,
    input logic       wake_evt,
    input logic       kick_evt,
    input logic       wake_ie,
    input logic       kick_ie,
    input logic       pwr_n,
    input logic       irq,
    input logic [7:0] reg_q
);
    // R4
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> reg_q[1]);

    // R4
    kick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_evt |=> reg_q[0]);

    // R9
    pwr_auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_q[1] && wake_ie) || (reg_q[0] && kick_ie)) |=> !pwr_n);

    // R3
    uip_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pending && !reg_q[6]) |=> reg_q[6]);

    // R3
    uip_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && reg_q[6]) |=> !reg_q[6]);

    // R11
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(reg_q[2:0]) != 0));
endmodule

bind rtc_xstat_reg rtc_xstat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_pending (upd_pending),
    .upd_done    (upd_done),
    .wake_evt    (wake_evt),
    .kick_evt    (kick_evt),
    .wake_ie     (wake_ie),
    .kick_ie     (kick_ie),
    .pwr_n       (pwr_n),
    .irq         (irq),
    .reg_q       (reg_q)
);

// File: tb/sim_rtc_xstat_reg.sv
module sim_rtc_xstat_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel = 1'b1;
    logic [6:0] addr = 7'h4A;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       batt_ok = 1'b1;
    logic       upd_pending = 1'b0, upd_done = 1'b0;
    logic       wake_evt = 1'b0, kick_evt = 1'b0;
    logic       ramclr_n = 1'b1, ramclr_en = 1'b0;
    logic       wake_ie = 1'b0, kick_ie = 1'b0, rf_ie = 1'b0;
    logic       pwr_n, irq;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic       m_wf, m_kf, m_rf, m_pab, m_uip;
    logic [1:0] m_res;
    logic       p1, p2, p3;

    always #10 clk = ~clk;

    rtc_xstat_reg u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .batt_ok(batt_ok),
        .upd_pending(upd_pending), .upd_done(upd_done),
        .wake_evt(wake_evt), .kick_evt(kick_evt), .ramclr_n(ramclr_n),
        .ramclr_en(ramclr_en), .wake_ie(wake_ie), .kick_ie(kick_ie),
        .rf_ie(rf_ie), .pwr_n(pwr_n), .irq(irq)
    );

    function automatic logic [7:0] exp_reg();
        return {batt_ok, m_uip, m_res, m_pab, m_rf, m_wf, m_kf};
    endfunction

    function automatic logic exp_hit();
        return bank_sel && (addr == 7'h4A);
    endfunction

    function automatic logic exp_irq();
        return (m_rf & rf_ie) | (m_wf & wake_ie) | (m_kf & kick_ie);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_wf = 0; m_kf = 0; m_rf = 0; m_pab = 1; m_uip = 0; m_res = 0;
        p1 = 1; p2 = 1; p3 = 1;
    endtask

    // one clock: model updated from pre-edge values, compared at the falling edge
    task automatic step();
        logic hit, clr, fall;
        @(posedge clk);
        hit  = wr_en && exp_hit();
        clr  = (m_wf & wake_ie) | (m_kf & kick_ie);
        fall = p3 & ~p2;
        m_pab = clr ? 1'b0 : (hit ? wdata[3] : m_pab);
        m_wf  = wake_evt ? 1'b1 : (hit ? wdata[1] : m_wf);
        m_kf  = kick_evt ? 1'b1 : (hit ? wdata[0] : m_kf);
        m_rf  = (fall && ramclr_en) ? 1'b1 : (hit ? wdata[2] : m_rf);
        if (hit) m_res = wdata[5:4];
        if (!m_uip && upd_pending) m_uip = 1'b1;
        else if (m_uip && upd_done) m_uip = 1'b0;
        p3 = p2; p2 = p1; p1 = ramclr_n;
        @(negedge clk);
        chk("R6 model rdata", rdata, exp_hit() ? exp_reg() : 8'h00);
        chk("R8 model pwr_n", {7'b0, pwr_n}, {7'b0, m_pab});
        chk("R11 model irq", {7'b0, irq}, {7'b0, exp_irq()});
    endtask

    task automatic idle();
        wr_en = 0; wake_evt = 0; kick_evt = 0; upd_pending = 0; upd_done = 0;
        bank_sel = 1; addr = 7'h4A;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset value", rdata, 8'h88);
        chk("R1 reset pwr_n", {7'b0, pwr_n}, 8'h01);
        batt_ok = 0; #1;
        chk("R2 battery low", rdata, 8'h08);

        // R6 R10 R2 R3: write all ones
        wr_en = 1; wdata = 8'hFF; step(); idle();
        chk("R6 R10 write ones, R2 R3 bits ignored", rdata, 8'h3F);
        wr_en = 1; wdata = 8'h00; step(); idle();
        chk("R6 write zero clears", rdata, 8'h00);
        chk("R8 pwr_n low when bit clear", {7'b0, pwr_n}, 8'h00);

        // R4 R11
        wake_evt = 1; step(); idle();
        chk("R4 wake flag set", rdata, 8'h02);
        chk("R11 irq masked", {7'b0, irq}, 8'h00);
        wake_ie = 1; #1;
        chk("R11 irq enabled", {7'b0, irq}, 8'h01);
        // R7 R9: write 0x08 colliding with wake event
        wr_en = 1; wdata = 8'h08; wake_evt = 1; step(); idle();
        chk("R7 set beats write zero, R9 auto clear beats write one", rdata, 8'h02);
        wake_ie = 0;
        wr_en = 1; wdata = 8'h08; step(); idle();
        chk("R8 power bit written", rdata, 8'h08);
        kick_evt = 1; step(); idle();
        chk("R4 kick flag set", rdata, 8'h09);
        wr_en = 1; wdata = 8'h08; step(); idle();

        // R5 disabled edge ignored
        ramclr_en = 0; ramclr_n = 0; repeat (4) step();
        chk("R5 edge ignored when disabled", rdata, 8'h08);
        ramclr_n = 1; repeat (4) step();
        ramclr_en = 1; ramclr_n = 0; step(); step();
        chk("R5 not yet after two edges", rdata, 8'h08);
        step();
        chk("R5 flag on third edge", rdata, 8'h0C);

        // R3 arm / finish
        upd_pending = 1; step(); idle();
        chk("R3 arm", rdata, 8'h4C);
        upd_done = 1; step(); idle();
        chk("R3 finish", rdata, 8'h0C);

        // R12 decode
        addr = 7'h4B; wr_en = 1; wdata = 8'hF0; step();
        chk("R12 other address reads zero", rdata, 8'h00);
        bank_sel = 0; addr = 7'h4A; step();
        chk("R12 other bank reads zero", rdata, 8'h00);
        idle(); #1;
        chk("R12 value untouched", rdata, 8'h0C);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            wr_en       = ($urandom % 4) == 0;
            wdata       = 8'($urandom);
            bank_sel    = ($urandom % 8) != 0;
            addr        = (($urandom % 8) == 0) ? 7'($urandom) : 7'h4A;
            wake_evt    = ($urandom % 10) == 0;
            kick_evt    = ($urandom % 10) == 0;
            upd_pending = ($urandom % 6) == 0;
            upd_done    = ($urandom % 6) == 0;
            if (($urandom % 5) == 0) ramclr_n = ~ramclr_n;
            if (($urandom % 16) == 0) ramclr_en = ~ramclr_en;
            if (($urandom % 16) == 0) wake_ie = ~wake_ie;
            if (($urandom % 16) == 0) kick_ie = ~kick_ie;
            if (($urandom % 16) == 0) rf_ie = ~rf_ie;
            if (($urandom % 32) == 0) batt_ok = ~batt_ok;
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule